// File: doc/BRIEF.md
# Speculative Register State with Gated Store Buffer

This block holds the architectural state that translated code blocks change while they run speculatively. Each register exists twice. A working copy takes every instruction write. A checkpoint copy keeps the state as it was at the last commit. Stores do not go to memory straight away. They wait in a small in-order buffer, and every load searches that buffer before memory data is used.

When a translated block ends, the control logic pulses `commit`. In one clock edge every working register is copied into its checkpoint copy, and the buffered stores start to leave through a valid/ready memory write port, one per handshake, in the order they were issued. When an exception occurs, the control logic pulses `rollback`. In one edge every working register is reloaded from its checkpoint copy and all uncommitted stores are thrown away. The trap therefore sees the exact state of the last commit point.

Top module: `ckpt_regstate`

## Requirements
- R1: After synchronous reset every register reads zero in both copies, `st_full`, `sb_busy`, `mw_valid` and `ld_hit` are low, and the read ports return zero.
- R2: A register write changes only the working copy. Read data is registered and appears on the edge after the index is presented. A read issued in the same cycle as a write to that register returns the old working value.
- R3: Write byte enable bit k (`wr_be[k]`) gates data bits 8k+7..8k. Lanes whose enable is low keep their previous value, so `wr_be` = 4'b0001 updates only the low 8 bits.
- R4: An accepted commit copies every working register into its checkpoint copy, and a register write in the same cycle is part of the copied state. Without an accepted commit the checkpoint copies never change.
- R5: Rollback reloads every working register from its checkpoint copy in one edge and discards a register write in the same cycle. When rollback and commit are both high, only rollback takes effect.
- R6: A store accepted into the buffer does not appear on the memory write port before an accepted commit.
- R7: A load presents `ld_addr` with the memory word `ld_mem_data`. One edge later `ld_hit` tells whether any pending buffered store has the same address. If so, `ld_data` is the data of the youngest such store; otherwise `ld_data` is the memory word. A store offered in the same cycle as the load is not seen by that load.
- R8: After a commit with pending stores, `sb_busy` and `mw_valid` rise on the commit edge. Entries drain oldest first, one per cycle with `mw_valid` and `mw_ready` both high, and address and data are held while `mw_ready` is low. `sb_busy` falls after the last transfer. A commit with an empty buffer leaves `sb_busy` low. A store offered in the commit cycle is accepted and drains last.
- R9: While `sb_busy` is high, stores and commits are ignored. A rollback still restores the registers, but the committed drain goes on to completion.
- R10: The buffer holds 8 entries. With 8 pending, `st_full` is high and a further store is dropped.
- R11: A rollback while not busy invalidates every buffered store, including one offered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ra_idx | input | 4 | Read port A register index |
| ra_data | output | 32 | Read port A data (registered) |
| rb_idx | input | 4 | Read port B register index |
| rb_data | output | 32 | Read port B data (registered) |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register write index |
| wr_be | input | 4 | Per-byte write enables |
| wr_data | input | 32 | Register write data |
| st_valid | input | 1 | Store request |
| st_addr | input | 32 | Store word address |
| st_data | input | 32 | Store data |
| st_full | output | 1 | Buffer holds 8 pending stores |
| sb_busy | output | 1 | Committed stores still draining |
| ld_addr | input | 32 | Load word address |
| ld_mem_data | input | 32 | Memory word for the load address |
| ld_hit | output | 1 | Load matched a buffered store |
| ld_data | output | 32 | Load result |
| commit | input | 1 | End-of-block commit strobe |
| rollback | input | 1 | Exception rollback strobe |
| mw_valid | output | 1 | Memory write request |
| mw_ready | input | 1 | Memory write accept |
| mw_addr | output | 32 | Memory write address |
| mw_data | output | 32 | Memory write data |

## Verification
The bench stores to one address twice and loads it back. A search that gave priority to the oldest match would return stale data. A load in the same cycle as a store must miss, or the design would be forwarding data it has not yet accepted. During a drain with a toggling ready, a store, a register write, a commit and a rollback are offered. A design that let any of them into the drain, or moved the checkpoint, shows up as an unexpected memory write or a wrong register after the rollback. Rollback and commit together, and a write in the same cycle as either strobe, check that the write is kept by a commit and discarded by a rollback, and that rollback has priority. A ninth store into a full buffer must never reach memory.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
  typedef enum logic [1:0] {
    OP_IDLE     = 2'd0,
    OP_COMMIT   = 2'd1,
    OP_ROLLBACK = 2'd2
  } ckpt_op_e;

  // Rollback dominates; a commit is only taken when no drain is running.
  function automatic ckpt_op_e ckpt_decode(input logic commit_i,
                                           input logic rollback_i,
                                           input logic busy_i);
    if (rollback_i)             return OP_ROLLBACK;
    if (commit_i && !busy_i)    return OP_COMMIT;
    return OP_IDLE;
  endfunction
endpackage

// File: rtl/ckpt_regbank.sv
module ckpt_regbank
  import ckpt_pkg::*;
#(
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int NB  = DW / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ckpt_op_e         op,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [NB-1:0]    wr_be,
  input  logic [DW-1:0]    wr_data,
  input  logic [IW-1:0]    ra_idx,
  input  logic [IW-1:0]    rb_idx,
  output logic [DW-1:0]    ra_data,
  output logic [DW-1:0]    rb_data,
  output logic [NREG*DW-1:0] work_vec,
  output logic [NREG*DW-1:0] shad_vec
);
  logic [DW-1:0] work_arr [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [DW-1:0] wq;
    logic [DW-1:0] sq;
    logic [DW-1:0] nxt;
    logic          sel;

    assign sel = wr_en && (wr_idx == IW'(r));

    for (genvar b = 0; b < NB; b++) begin : g_lane
      assign nxt[b*8 +: 8] = (sel && wr_be[b]) ? wr_data[b*8 +: 8] : wq[b*8 +: 8];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        wq <= '0;
        sq <= '0;
      end else if (op == OP_ROLLBACK) begin
        wq <= sq;
      end else begin
        wq <= nxt;
        if (op == OP_COMMIT) sq <= nxt;
      end
    end

    assign work_arr[r]          = wq;
    assign work_vec[r*DW +: DW] = wq;
    assign shad_vec[r*DW +: DW] = sq;
  end

  // Registered read ports sample the working copy before this edge's write.
  always_ff @(posedge clk) begin
    if (rst) begin
      ra_data <= '0;
      rb_data <= '0;
    end else begin
      ra_data <= work_arr[ra_idx];
      rb_data <= work_arr[rb_idx];
    end
  end
endmodule

// File: rtl/ckpt_stbuf.sv
module ckpt_stbuf
  import ckpt_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  ckpt_op_e      op,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          st_full,
  output logic          busy,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_mem_data,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  output logic          mw_valid,
  input  logic          mw_ready,
  output logic [AW-1:0] mw_addr,
  output logic [DW-1:0] mw_data
);
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] dptr_q;
  logic          busy_q;
  logic          accept;
  logic [CW-1:0] cnt_n;
  logic          snoop_hit;
  logic [DW-1:0] snoop_data;

  assign st_full = (cnt_q == CW'(DEPTH));
  assign accept  = st_valid && !busy_q && !st_full && (op != OP_ROLLBACK);
  assign cnt_n   = cnt_q + CW'(accept);

  // Entries are appended in program order at index cnt_q.
  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q[cnt_q[PW-1:0]] <= st_addr;
      data_q[cnt_q[PW-1:0]] <= st_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      dptr_q <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (mw_ready) begin
        if (CW'(dptr_q) == cnt_q - CW'(1)) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
          dptr_q <= '0;
        end else begin
          dptr_q <= dptr_q + PW'(1);
        end
      end
    end else if (op == OP_ROLLBACK) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      if (op == OP_COMMIT && cnt_n != '0) begin
        busy_q <= 1'b1;
        dptr_q <= '0;
      end
    end
  end

  // Later matches overwrite earlier ones: youngest pending store wins.
  always_comb begin
    snoop_hit  = 1'b0;
    snoop_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CW'(i) < cnt_q) && (addr_q[i] == ld_addr)) begin
        snoop_hit  = 1'b1;
        snoop_data = data_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_hit  <= 1'b0;
      ld_data <= '0;
    end else begin
      ld_hit  <= snoop_hit;
      ld_data <= snoop_hit ? snoop_data : ld_mem_data;
    end
  end

  assign busy     = busy_q;
  assign mw_valid = busy_q;
  assign mw_addr  = addr_q[dptr_q];
  assign mw_data  = data_q[dptr_q];
endmodule

// File: rtl/ckpt_regstate.sv
module ckpt_regstate
  import ckpt_pkg::*;
#(
  parameter int NREG     = 16,
  parameter int DW       = 32,
  parameter int AW       = 32,
  parameter int SB_DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(NREG)-1:0]  ra_idx,
  output logic [DW-1:0]            ra_data,
  input  logic [$clog2(NREG)-1:0]  rb_idx,
  output logic [DW-1:0]            rb_data,
  input  logic                     wr_en,
  input  logic [$clog2(NREG)-1:0]  wr_idx,
  input  logic [DW/8-1:0]          wr_be,
  input  logic [DW-1:0]            wr_data,
  input  logic                     st_valid,
  input  logic [AW-1:0]            st_addr,
  input  logic [DW-1:0]            st_data,
  output logic                     st_full,
  output logic                     sb_busy,
  input  logic [AW-1:0]            ld_addr,
  input  logic [DW-1:0]            ld_mem_data,
  output logic                     ld_hit,
  output logic [DW-1:0]            ld_data,
  input  logic                     commit,
  input  logic                     rollback,
  output logic                     mw_valid,
  input  logic                     mw_ready,
  output logic [AW-1:0]            mw_addr,
  output logic [DW-1:0]            mw_data
);
  ckpt_op_e            op;
  logic [NREG*DW-1:0]  work_vec;
  logic [NREG*DW-1:0]  shad_vec;

  assign op = ckpt_decode(commit, rollback, sb_busy);

  ckpt_regbank #(.NREG(NREG), .DW(DW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_be    (wr_be),
    .wr_data  (wr_data),
    .ra_idx   (ra_idx),
    .rb_idx   (rb_idx),
    .ra_data  (ra_data),
    .rb_data  (rb_data),
    .work_vec (work_vec),
    .shad_vec (shad_vec)
  );

  ckpt_stbuf #(.DEPTH(SB_DEPTH), .AW(AW), .DW(DW)) u_sbuf (
    .clk         (clk),
    .rst         (rst),
    .op          (op),
    .st_valid    (st_valid),
    .st_addr     (st_addr),
    .st_data     (st_data),
    .st_full     (st_full),
    .busy        (sb_busy),
    .ld_addr     (ld_addr),
    .ld_mem_data (ld_mem_data),
    .ld_hit      (ld_hit),
    .ld_data     (ld_data),
    .mw_valid    (mw_valid),
    .mw_ready    (mw_ready),
    .mw_addr     (mw_addr),
    .mw_data     (mw_data)
  );
endmodule

// File: rtl/ckpt_regstate_chk.sv
module ckpt_regstate_chk #(
  parameter int VW = 512,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          commit,
  input logic          rollback,
  input logic          sb_busy,
  input logic          st_full,
  input logic          st_valid,
  input logic          mw_valid,
  input logic          mw_ready,
  input logic [AW-1:0] mw_addr,
  input logic [DW-1:0] mw_data,
  input logic [VW-1:0] work_vec,
  input logic [VW-1:0] shad_vec
);
  // R8: a stalled memory write keeps its request and payload
  assert_drain_hold_R8: assert property (@(posedge clk) disable iff (rst)
    mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data));

  // R6: nothing reaches memory unless a commit was taken
  assert_no_early_write_R6: assert property (@(posedge clk) disable iff (rst)
    !sb_busy && !(commit && !rollback) |=> !mw_valid);

  // R5: after a rollback the working copy equals the checkpoint copy
  assert_rollback_restore_R5: assert property (@(posedge clk) disable iff (rst)
    rollback |=> work_vec == shad_vec);

  // R4: an accepted commit leaves both copies equal
  assert_commit_copy_R4: assert property (@(posedge clk) disable iff (rst)
    commit && !rollback && !sb_busy |=> shad_vec == work_vec);

  // R4, R9: checkpoint copy only moves on an accepted commit
  assert_shadow_stable_R9: assert property (@(posedge clk) disable iff (rst)
    !(commit && !rollback && !sb_busy) |=> $stable(shad_vec));

  // R10: a store into a full buffer does not lower the full flag
  assert_full_drop_R10: assert property (@(posedge clk) disable iff (rst)
    st_full && st_valid && !rollback && !sb_busy |=> st_full);

  // R11: an idle rollback empties the buffer
  assert_rollback_flush_R11: assert property (@(posedge clk) disable iff (rst)
    rollback && !sb_busy |=> !mw_valid && !st_full);
endmodule

bind ckpt_regstate ckpt_regstate_chk #(.VW(NREG*DW), .AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .commit   (commit),
  .rollback (rollback),
  .sb_busy  (sb_busy),
  .st_full  (st_full),
  .st_valid (st_valid),
  .mw_valid (mw_valid),
  .mw_ready (mw_ready),
  .mw_addr  (mw_addr),
  .mw_data  (mw_data),
  .work_vec (work_vec),
  .shad_vec (shad_vec)
);

// File: tb/sim_ckpt_regstate.sv
`timescale 1ns/1ps
module sim_ckpt_regstate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ra_idx = '0, rb_idx = '0, wr_idx = '0;
  logic [31:0] ra_data, rb_data;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0, st_data = '0;
  logic        st_full, sb_busy;
  logic [31:0] ld_addr = '0, ld_mem_data = '0;
  logic        ld_hit;
  logic [31:0] ld_data;
  logic        commit = 1'b0, rollback = 1'b0;
  logic        mw_valid;
  logic        mw_ready = 1'b1;
  logic [31:0] mw_addr, mw_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] exp_work [16];
  logic [31:0] exp_shad [16];
  logic [63:0] pend [$];
  logic [63:0] sbq [$];

  always #2.5 clk = ~clk;

  ckpt_regstate u0 (
    .clk(clk), .rst(rst),
    .ra_idx(ra_idx), .ra_data(ra_data), .rb_idx(rb_idx), .rb_data(rb_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_be(wr_be), .wr_data(wr_data),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .st_full(st_full), .sb_busy(sb_busy),
    .ld_addr(ld_addr), .ld_mem_data(ld_mem_data), .ld_hit(ld_hit), .ld_data(ld_data),
    .commit(commit), .rollback(rollback),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return ~a ^ 32'h0F0F_0000;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_in();
    wr_en = 1'b0; wr_be = '0; st_valid = 1'b0; commit = 1'b0; rollback = 1'b0;
  endtask

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = n[b*8 +: 8];
    return r;
  endfunction

  // Model a register write; the caller decides whether a strobe accompanies it.
  task automatic set_wr(input int idx, input logic [3:0] be, input logic [31:0] d);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_be = be; wr_data = d;
  endtask

  task automatic wr(input int idx, input logic [3:0] be, input logic [31:0] d);
    set_wr(idx, be, d);
    tick();
    clear_in();
    exp_work[idx] = merge(exp_work[idx], d, be);
  endtask

  task automatic rd_chk(input int idx, input string tag);
    ra_idx = 4'(idx); rb_idx = 4'(idx);
    tick();
    chk(tag, {32'h0, ra_data}, {32'h0, exp_work[idx]});
    chk(tag, {32'h0, rb_data}, {32'h0, exp_work[idx]});
  endtask

  task automatic st(input logic [31:0] a, input logic [31:0] d, input bit take);
    st_valid = 1'b1; st_addr = a; st_data = d;
    tick();
    clear_in();
    if (take) pend.push_back({a, d});
  endtask

  task automatic ld(input logic [31:0] a, input bit hit, input logic [31:0] d,
                    input string tag);
    ld_addr = a; ld_mem_data = memf(a);
    tick();
    chk(tag, {63'h0, ld_hit}, {63'h0, hit});
    chk(tag, {32'h0, ld_data}, {32'h0, hit ? d : memf(a)});
  endtask

  task automatic take_commit();
    for (int r = 0; r < 16; r++) exp_shad[r] = exp_work[r];
    while (pend.size() > 0) sbq.push_back(pend.pop_front());
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && sb_busy; i++) begin
      mw_ready = ~mw_ready;
      tick();
    end
    mw_ready = 1'b1;
  endtask

  // Scoreboard monitor: every memory write must match the next expected drain.
  always @(negedge clk) begin
    if (!rst && mw_valid && mw_ready) begin
      if (sbq.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R8 unexpected write actual=%h expected=none", {mw_addr, mw_data});
      end else begin
        chk("R8 drain order", {mw_addr, mw_data}, sbq.pop_front());
      end
    end
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 16; r++) begin exp_work[r] = '0; exp_shad[r] = '0; end
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R1 reset state
    chk("R1 flags", {60'h0, st_full, sb_busy, mw_valid, ld_hit}, 64'h0);
    rd_chk(3, "R1 reg3");

    // R2 write hits working copy; same-cycle read sees old value
    set_wr(5, 4'hF, 32'h1122_3344); ra_idx = 4'd5; rb_idx = 4'd5;
    tick(); clear_in();
    chk("R2 old value", {32'h0, ra_data}, 64'h0);
    exp_work[5] = 32'h1122_3344;
    rd_chk(5, "R2 new value");

    // R3 byte lanes
    wr(5, 4'b0001, 32'hFFFF_FFAA);
    rd_chk(5, "R3 low byte");
    wr(5, 4'b0100, 32'h00BB_0000);
    rd_chk(5, "R3 lane2");

    // R6, R7 buffered stores and snooping
    st(32'h100, 32'hD1, 1);
    st(32'h200, 32'hD2, 1);
    st(32'h100, 32'hD3, 1);
    chk("R6 no write before commit", {63'h0, mw_valid}, 64'h0);
    ld(32'h100, 1, 32'hD3, "R7 youngest");
    ld(32'h200, 1, 32'hD2, "R7 hit");
    ld(32'h300, 0, 0, "R7 miss");
    st_valid = 1'b1; st_addr = 32'h400; st_data = 32'hD4;
    ld_addr = 32'h400; ld_mem_data = memf(32'h400);
    tick(); clear_in();
    pend.push_back({32'h400, 32'hD4});
    chk("R7 same-cycle store unseen", {63'h0, ld_hit}, 64'h0);
    ld(32'h400, 1, 32'hD4, "R7 hit after store");

    // R4 commit with same-cycle write; R8 drain starts
    mw_ready = 1'b0;
    set_wr(6, 4'hF, 32'h6666_0006); commit = 1'b1;
    tick(); clear_in();
    exp_work[6] = 32'h6666_0006;
    take_commit();
    chk("R8 busy", {62'h0, sb_busy, mw_valid}, 64'h3);

    // R9 ignored inputs during drain
    st(32'h700, 32'hD7, 0);
    wr(7, 4'hF, 32'h7777_0007);
    commit = 1'b1; tick(); clear_in();
    rollback = 1'b1; tick(); clear_in();
    for (int r = 0; r < 16; r++) exp_work[r] = exp_shad[r];
    chk("R9 drain continues", {63'h0, mw_valid}, 64'h1);
    rd_chk(7, "R9 commit ignored");
    rd_chk(6, "R4 same-cycle write committed");
    wait_idle();
    chk("R8 queue empty", 64'(sbq.size()), 64'h0);
    chk("R8 idle", {63'h0, sb_busy}, 64'h0);
    ld(32'h700, 0, 0, "R9 store ignored");

    // R5, R11 rollback beats commit and discards stores and writes
    st(32'h500, 32'hD5, 1);
    set_wr(2, 4'hF, 32'h2222_2222); commit = 1'b1; rollback = 1'b1;
    st_valid = 1'b1; st_addr = 32'h600; st_data = 32'hD6;
    tick(); clear_in();
    pend.delete();
    chk("R5 rollback wins", {63'h0, sb_busy}, 64'h0);
    ld(32'h500, 0, 0, "R11 store discarded");
    ld(32'h600, 0, 0, "R11 same-cycle store discarded");
    rd_chk(2, "R5 write discarded");
    rd_chk(5, "R5 restored");
    repeat (3) tick();

    // R10 full buffer
    for (int i = 0; i < 8; i++) st(32'h1000 + 32'(i), 32'hE0 + 32'(i), 1);
    chk("R10 full", {63'h0, st_full}, 64'h1);
    st(32'h2000, 32'hEE, 0);
    ld(32'h2000, 0, 0, "R10 dropped");
    commit = 1'b1; tick(); clear_in();
    take_commit();
    wait_idle();
    chk("R10 all drained", 64'(sbq.size()), 64'h0);
    chk("R10 not full", {63'h0, st_full}, 64'h0);

    // R8 commit on empty buffer
    commit = 1'b1; tick(); clear_in();
    chk("R8 empty commit", {63'h0, sb_busy}, 64'h0);
    repeat (3) tick();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule